// File: doc/BRIEF.md
# Five-State Snooping Coherence Controller

This block keeps one private cache coherent with its peers on a shared snooping bus. It holds a small direct-mapped array of one-word lines. Each line carries a state, a tag and a data word. Each line is in one of five states: invalid, shared-clean, exclusive-clean, owned-dirty or modified-dirty. Local loads and stores arrive on a valid/ready request port. Transactions issued by other caches arrive on the snoop port, and the block reacts to them in the same cycle.

A request is accepted on a clock edge where `cpu_valid` and `cpu_ready` are both high. The requester must hold the request fields steady until that edge. `cpu_ready` stays low while a request is in progress and in any cycle where a snoop is being presented. The result comes back as a single-cycle `rsp_valid` pulse. That pulse has no back-pressure, so the requester must sample it when it appears.

On the bus side the block raises `bus_req` and holds the command and address until `bus_gnt` arrives. The grant cycle is the transaction. In that cycle the arbiter shows it to every other controller as a snoop. The arbiter returns the wired-OR of all peers' `snp_shared` outputs on `bus_shared`. It also returns on `bus_rdata` the data of the one peer asserting `snp_supply`, or the memory word when no peer supplies. Dirty data can be shared without touching memory, because the supplier keeps responsibility in the owned state. A clean exclusive line can be written with no bus traffic.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready` is high, and `bus_req` and `rsp_valid` are low.
- R2: A read miss issues command 0 (read) for the requested address. At the grant the line fills as exclusive if `bus_shared` is low and as shared if it is high. The response carries `bus_rdata`.
- R3: A write that hits an exclusive or modified line completes with no bus request and leaves the line modified.
- R4: A write that hits a shared or owned line issues command 2 (invalidate) and then becomes modified. If the copy was invalidated while the block waited for the grant, the block issues command 1 (read-exclusive) instead.
- R5: A snooped read that hits a modified line asserts `snp_shared` and `snp_supply` with the line's data. The line moves to owned, and no writeback (command 3) is issued.
- R6: A snooped read that hits an exclusive line asserts `snp_shared` without supplying data, and the line drops to shared. A shared line also asserts `snp_shared`.
- R7: A snooped read that hits an owned line supplies its data and asserts `snp_shared`. The line stays owned.
- R8: A snooped read-exclusive (1) or invalidate (2) that hits any valid line moves it to invalid. A modified or owned holder supplies data on read-exclusive only.
- R9: The index is the low log2(sets) address bits. A miss whose victim is modified or owned first issues command 3 with the victim address and data, then the fill. A clean victim is dropped silently.
- R10: `bus_req` and `bus_addr` stay steady until `bus_gnt` for every command except writeback. A writeback request is withdrawn if a snoop has already taken the dirty data. The array never takes a local and a snoop update to one line in one cycle.
- R11: Across several controllers on one bus, every read returns the value of the last write to that address. At most one controller supplies data in any transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Local request valid |
| cpu_ready | output | 1 | Local request accepted this edge when high |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Load data (store data echoed for stores) |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 read, 1 read-exclusive, 2 invalidate, 3 writeback |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_gnt | input | 1 | Grant; the transaction happens in this cycle |
| bus_shared | input | 1 | Wired-OR of peers' shared outputs |
| bus_rdata | input | DATA_W | Fill data from a peer or memory |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line (read only) |
| snp_supply | output | 1 | This cache drives the line's data |
| snp_data | output | DATA_W | Supplied data |

## Verification
A hit completes at the accepting edge, so `rsp_valid` is visible in the following cycle. A miss or upgrade completes at the grant edge, which comes one cycle after `bus_req` rises at the earliest, plus one more grant cycle when a writeback comes first. Snoop outputs are combinational and valid in the grant cycle itself. The bench drives and samples only on falling edges. Its task waits on `cpu_ready` and then on `rsp_valid`, so it never assumes a fixed latency. Bus effects are counted at the falling edge inside each grant cycle, so each count is read only after the operation that caused it has responded.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_E = 3'd2,
    ST_O = 3'd3,
    ST_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_UPG = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_t;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_WB,
    FS_FILL,
    FS_UPG
  } fsm_st_t;

  function automatic logic is_dirty(line_st_t s);
    return (s == ST_M) || (s == ST_O);
  endfunction
endpackage

// File: rtl/moesi_line_array.sv
module moesi_line_array
  import moesi_pkg::*;
#(
  parameter int SETS   = 4,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st,
  input  logic              lw_en,
  input  logic [IDX_W-1:0]  lw_idx,
  input  line_st_t          lw_st,
  input  logic [TAG_W-1:0]  lw_tag,
  input  logic [DATA_W-1:0] lw_data,
  output logic [SETS*3-1:0] st_all
);
  line_st_t          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              st_q[s] <= ST_I;
      else if (lw_en && lw_idx == IDX_W'(s))   st_q[s] <= lw_st;
      else if (sw_en && sw_idx == IDX_W'(s))   st_q[s] <= sw_st;
    end
    always_ff @(posedge clk) begin
      if (lw_en && lw_idx == IDX_W'(s)) begin
        tag_q[s]  <= lw_tag;
        data_q[s] <= lw_data;
      end
    end
    assign st_all[s*3 +: 3] = 3'(st_q[s]);
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_en && sw_en) |-> (lw_idx != sw_idx)); // R10
endmodule

// File: rtl/moesi_snoop_resp.sv
module moesi_snoop_resp
  import moesi_pkg::*;
(
  input  logic     snp_valid,
  input  bus_cmd_t snp_cmd,
  input  line_st_t st,
  input  logic     tag_hit,
  output logic     hit,
  output logic     shared,
  output logic     supply,
  output logic     upd,
  output line_st_t nst
);
  always_comb begin
    hit    = snp_valid && (st != ST_I) && tag_hit;
    shared = 1'b0;
    supply = 1'b0;
    upd    = 1'b0;
    nst    = st;
    unique case (snp_cmd)
      BC_RD: begin
        shared = hit;
        supply = hit && is_dirty(st);
        upd    = hit;
        nst    = is_dirty(st) ? ST_O : ST_S;
      end
      BC_RDX: begin
        supply = hit && is_dirty(st);
        upd    = hit;
        nst    = ST_I;
      end
      BC_UPG: begin
        upd = hit;
        nst = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/moesi_req_fsm.sv
module moesi_req_fsm
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              snp_valid,
  output logic [IDX_W-1:0]  a_idx,
  input  line_st_t          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  output logic              lw_en,
  output line_st_t          lw_st,
  output logic [TAG_W-1:0]  lw_tag,
  output logic [DATA_W-1:0] lw_data,
  output logic              bus_req,
  output bus_cmd_t          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata
);
  fsm_st_t           fs;
  logic              q_wr;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              hit, accept, excl_wr;

  assign cur_addr  = (fs == FS_IDLE) ? cpu_addr : q_addr;
  assign a_idx     = cur_addr[IDX_W-1:0];
  assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];
  assign hit       = (a_st != ST_I) && (a_tag == cur_tag);
  assign cpu_ready = (fs == FS_IDLE) && !snp_valid;
  assign accept    = cpu_valid && cpu_ready;
  assign excl_wr   = (a_st == ST_E) || (a_st == ST_M);

  always_comb begin
    bus_req   = 1'b0;
    bus_cmd   = BC_RD;
    bus_addr  = q_addr;
    bus_wdata = a_data;
    lw_en     = 1'b0;
    lw_st     = a_st;
    lw_tag    = a_tag;
    lw_data   = a_data;
    unique case (fs)
      FS_IDLE: begin
        if (accept && hit && cpu_write && excl_wr) begin
          lw_en   = 1'b1;
          lw_st   = ST_M;
          lw_data = cpu_wdata;
        end
      end
      FS_WB: begin
        if (is_dirty(a_st)) begin
          bus_req  = 1'b1;
          bus_cmd  = BC_WB;
          bus_addr = {a_tag, a_idx};
          if (bus_gnt) begin
            lw_en = 1'b1;
            lw_st = ST_I;
          end
        end
      end
      FS_FILL: begin
        bus_req = 1'b1;
        bus_cmd = q_wr ? BC_RDX : BC_RD;
        if (bus_gnt) begin
          lw_en   = 1'b1;
          lw_tag  = cur_tag;
          lw_st   = q_wr ? ST_M : (bus_shared ? ST_S : ST_E);
          lw_data = q_wr ? q_wdata : bus_rdata;
        end
      end
      FS_UPG: begin
        bus_req = 1'b1;
        bus_cmd = hit ? BC_UPG : BC_RDX;
        if (bus_gnt) begin
          lw_en   = 1'b1;
          lw_tag  = cur_tag;
          lw_st   = ST_M;
          lw_data = q_wdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs        <= FS_IDLE;
      q_wr      <= 1'b0;
      q_addr    <= '0;
      q_wdata   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (fs)
        FS_IDLE: begin
          if (accept) begin
            q_wr    <= cpu_write;
            q_addr  <= cpu_addr;
            q_wdata <= cpu_wdata;
            if (hit && !cpu_write) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= a_data;
            end else if (hit && excl_wr) begin
              rsp_valid <= 1'b1;
              rsp_rdata <= cpu_wdata;
            end else if (hit) begin
              fs <= FS_UPG;
            end else begin
              fs <= is_dirty(a_st) ? FS_WB : FS_FILL;
            end
          end
        end
        FS_WB: if (!is_dirty(a_st) || bus_gnt) fs <= FS_FILL;
        default: begin
          if (bus_gnt) begin
            fs        <= FS_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= lw_data;
          end
        end
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && bus_cmd != BC_WB) |=> (bus_req && $stable(bus_addr))); // R10
  AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> bus_req); // R10
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, snp_idx;
  line_st_t          a_st, b_st, lw_st, sw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, lw_tag, snp_tag;
  logic [DATA_W-1:0] a_data, b_data, lw_data;
  logic              lw_en, sw_en, snp_hit;
  logic [SETS*3-1:0] st_all;
  bus_cmd_t          fsm_cmd, scmd;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign scmd    = bus_cmd_t'(snp_cmd);
  assign bus_cmd = fsm_cmd;

  moesi_line_array #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk, .rst_n,
    .a_idx, .a_st, .a_tag, .a_data,
    .b_idx(snp_idx), .b_st, .b_tag, .b_data,
    .sw_en, .sw_idx(snp_idx), .sw_st,
    .lw_en, .lw_idx(a_idx), .lw_st, .lw_tag, .lw_data,
    .st_all
  );

  moesi_snoop_resp u_snoop (
    .snp_valid, .snp_cmd(scmd), .st(b_st), .tag_hit(b_tag == snp_tag),
    .hit(snp_hit), .shared(snp_shared), .supply(snp_supply), .upd(sw_en), .nst(sw_st)
  );
  assign snp_data = b_data;

  moesi_req_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk, .rst_n,
    .cpu_valid, .cpu_ready, .cpu_write, .cpu_addr, .cpu_wdata,
    .rsp_valid, .rsp_rdata, .snp_valid,
    .a_idx, .a_st, .a_tag, .a_data,
    .lw_en, .lw_st, .lw_tag, .lw_data,
    .bus_req, .bus_cmd(fsm_cmd), .bus_addr, .bus_wdata,
    .bus_gnt, .bus_shared, .bus_rdata
  );

  AST_M_TO_O: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && scmd == BC_RD && b_st == ST_M)
      |=> (st_all[$past(snp_idx)*3 +: 3] == 3'(ST_O))); // R5
  AST_O_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && scmd == BC_RD && b_st == ST_O) |-> (snp_supply && snp_shared)); // R7
  AST_EXCL_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && (scmd == BC_RDX || scmd == BC_UPG))
      |=> (st_all[$past(snp_idx)*3 +: 3] == 3'(ST_I))); // R8
  AST_SUPPLY_ON_READS: assert property (@(posedge clk) disable iff (!rst_n)
    snp_supply |-> (snp_valid && (scmd == BC_RD || scmd == BC_RDX))); // R8
  AST_WB_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && fsm_cmd == BC_WB)
      |-> (st_all[bus_addr[IDX_W-1:0]*3 +: 3] == 3'(ST_M)
        || st_all[bus_addr[IDX_W-1:0]*3 +: 3] == 3'(ST_O))); // R9
endmodule

// File: tb/moesi_snoop_ctrl_tb.sv
module moesi_snoop_ctrl_tb;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NC-1:0] cpu_valid, cpu_ready, cpu_write, rsp_valid;
  logic [NC-1:0] bus_req, gnt, snp_valid, snp_shared, snp_supply;
  logic [7:0]    cpu_addr [NC];
  logic [15:0]   cpu_wdata [NC];
  logic [15:0]   rsp_rdata [NC];
  logic [1:0]    bus_cmd [NC];
  logic [7:0]    bus_addr [NC];
  logic [15:0]   bus_wdata [NC];
  logic [15:0]   snp_data [NC];
  logic          any_g, shared_or, hold;
  int            gid;
  logic [1:0]    g_cmd;
  logic [7:0]    g_addr;
  logic [15:0]   g_rdata;
  logic [15:0]   mem [256];
  logic [15:0]   refm [256];

  int checks = 0, fails = 0, cyc = 0;
  int cnt [NC], sup_cnt [NC], last_cmd [NC], last_shared [NC];
  int wb_cnt = 0, last_wb_addr = -1;

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 257) ^ 16'h5a5a;
  endfunction

  for (genvar g = 0; g < NC; g++) begin : g_c
    moesi_snoop_ctrl u_dut (
      .clk, .rst_n,
      .cpu_valid(cpu_valid[g]), .cpu_ready(cpu_ready[g]), .cpu_write(cpu_write[g]),
      .cpu_addr(cpu_addr[g]), .cpu_wdata(cpu_wdata[g]),
      .rsp_valid(rsp_valid[g]), .rsp_rdata(rsp_rdata[g]),
      .bus_req(bus_req[g]), .bus_cmd(bus_cmd[g]), .bus_addr(bus_addr[g]), .bus_wdata(bus_wdata[g]),
      .bus_gnt(gnt[g]), .bus_shared(shared_or), .bus_rdata(g_rdata),
      .snp_valid(snp_valid[g]), .snp_cmd(g_cmd), .snp_addr(g_addr),
      .snp_shared(snp_shared[g]), .snp_supply(snp_supply[g]), .snp_data(snp_data[g])
    );
  end

  // Fixed-priority arbiter and bus fabric model
  always_comb begin
    gnt = '0; any_g = 1'b0; gid = 0;
    for (int i = 0; i < NC; i++)
      if (!any_g && bus_req[i] && !hold) begin gnt[i] = 1'b1; any_g = 1'b1; gid = i; end
    g_cmd  = bus_cmd[gid];
    g_addr = bus_addr[gid];
    for (int j = 0; j < NC; j++) snp_valid[j] = any_g && (j != gid);
    shared_or = |snp_shared;
    g_rdata = mem[g_addr];
    for (int j = 0; j < NC; j++) if (snp_supply[j]) g_rdata = snp_data[j];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Bus monitor, sampled mid-cycle
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end else if (any_g) begin
      int nsup;
      cnt[gid]++;
      last_cmd[gid] = int'(g_cmd);
      last_shared[gid] = int'(shared_or);
      nsup = 0;
      for (int j = 0; j < NC; j++) if (snp_supply[j]) begin sup_cnt[j]++; nsup++; end
      chk(nsup <= 1, "R11 single supplier", nsup, 1);
      for (int j = 0; j < NC; j++)
        if (snp_valid[j]) chk(!cpu_ready[j], "R10 ready low during snoop", int'(cpu_ready[j]), 0);
      if (g_cmd == 2'd3) begin
        mem[g_addr] = bus_wdata[gid];
        wb_cnt++;
        last_wb_addr = int'(g_addr);
      end
    end
  end

  task automatic op(input int c, input bit w, input logic [7:0] a, input logic [15:0] d,
                    input string req);
    @(negedge clk);
    cpu_valid[c] = 1'b1; cpu_write[c] = w; cpu_addr[c] = a; cpu_wdata[c] = d;
    while (!cpu_ready[c]) @(negedge clk);
    @(negedge clk);
    cpu_valid[c] = 1'b0;
    while (!rsp_valid[c]) @(negedge clk);
    if (w) refm[a] = d;
    else chk(rsp_rdata[c] == refm[a], req, int'(rsp_rdata[c]), int'(refm[a]));
  endtask

  initial begin
    int n, s, wbs;
    logic [7:0] aset [4];
    aset[0] = 8'h04; aset[1] = 8'h08; aset[2] = 8'h05; aset[3] = 8'h0c;
    cpu_valid = '0; cpu_write = '0; hold = 1'b0;
    for (int c = 0; c < NC; c++) begin
      cpu_addr[c] = '0; cpu_wdata[c] = '0;
      cnt[c] = 0; sup_cnt[c] = 0; last_cmd[c] = -1; last_shared[c] = -1;
    end
    for (int i = 0; i < 256; i++) refm[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_ready == 3'b111, "R1 ready", int'(cpu_ready), 7);
    chk(bus_req == 3'b000, "R1 bus_req", int'(bus_req), 0);
    chk(rsp_valid == 3'b000, "R1 rsp_valid", int'(rsp_valid), 0);

    // R2: cold read fills exclusive (no peer copy)
    op(0, 0, 8'h04, 0, "R2 fill data");
    chk(cnt[0] == 1, "R2 one bus read", cnt[0], 1);
    chk(last_cmd[0] == 0, "R2 read cmd", last_cmd[0], 0);
    chk(last_shared[0] == 0, "R2 shared low", last_shared[0], 0);
    // R3: writes to exclusive then modified are silent
    op(0, 1, 8'h04, 16'h1111, "R3");
    op(0, 1, 8'h04, 16'h1112, "R3");
    chk(cnt[0] == 1, "R3 no bus traffic", cnt[0], 1);

    // R5: peer read of modified line
    s = sup_cnt[0]; wbs = wb_cnt;
    op(1, 0, 8'h04, 0, "R5 supplied data");
    chk(sup_cnt[0] == s + 1, "R5 modified supplies", sup_cnt[0], s + 1);
    chk(last_shared[1] == 1, "R5 shared high", last_shared[1], 1);
    chk(wb_cnt == wbs, "R5 no writeback", wb_cnt, wbs);
    chk(mem[4] == init_val(4), "R5 memory untouched", int'(mem[4]), int'(init_val(4)));
    // R7: owned keeps supplying
    op(2, 0, 8'h04, 0, "R7 data");
    chk(sup_cnt[0] == s + 2, "R7 owned supplies", sup_cnt[0], s + 2);

    // R4: shared copy upgrades with invalidate
    op(1, 1, 8'h04, 16'h2222, "R4");
    chk(last_cmd[1] == 2, "R4 invalidate cmd", last_cmd[1], 2);
    n = cnt[0]; s = sup_cnt[1];
    op(0, 0, 8'h04, 0, "R8 data after invalidate");
    chk(cnt[0] == n + 1, "R8 owner lost copy", cnt[0], n + 1);
    chk(sup_cnt[1] == s + 1, "R8 new modified supplies", sup_cnt[1], s + 1);
    // R8: invalidated sharer writes with read-exclusive, owner supplies
    op(2, 1, 8'h04, 16'h3333, "R8");
    chk(last_cmd[2] == 1, "R8 read-exclusive cmd", last_cmd[2], 1);
    chk(sup_cnt[1] == s + 2, "R8 owned supplies on rdx", sup_cnt[1], s + 2);
    n = cnt[0];
    op(0, 0, 8'h04, 0, "R8 data");
    chk(cnt[0] == n + 1, "R8 rdx invalidated peer", cnt[0], n + 1);

    // R9: dirty (owned) victim writes back before fill
    n = cnt[2]; wbs = wb_cnt;
    op(2, 0, 8'h08, 0, "R9 fill data");
    chk(wb_cnt == wbs + 1, "R9 writeback issued", wb_cnt, wbs + 1);
    chk(last_wb_addr == 4, "R9 victim address", last_wb_addr, 4);
    chk(mem[4] == 16'h3333, "R9 victim data", int'(mem[4]), 16'h3333);
    chk(cnt[2] == n + 2, "R9 two transactions", cnt[2], n + 2);
    chk(last_cmd[2] == 0, "R9 fill after wb", last_cmd[2], 0);
    op(2, 0, 8'h04, 0, "R9 refetch data");
    chk(wb_cnt == wbs + 1, "R9 clean victim silent", wb_cnt, wbs + 1);
    chk(cnt[2] == n + 3, "R9 single fill", cnt[2], n + 3);

    // R6: exclusive demoted to shared by peer read
    op(0, 0, 8'h05, 0, "R2 data");
    chk(last_shared[0] == 0, "R2 exclusive fill", last_shared[0], 0);
    s = sup_cnt[0];
    op(1, 0, 8'h05, 0, "R6 data");
    chk(last_shared[1] == 1, "R6 shared asserted", last_shared[1], 1);
    chk(sup_cnt[0] == s, "R6 exclusive no supply", sup_cnt[0], s);
    n = cnt[0];
    op(0, 1, 8'h05, 16'h4444, "R6");
    chk(cnt[0] == n + 1 && last_cmd[0] == 2, "R6 demoted needs invalidate", last_cmd[0], 2);
    op(1, 0, 8'h05, 0, "R5 data");
    chk(sup_cnt[0] == s + 1, "R5 supply", sup_cnt[0], s + 1);
    n = cnt[0];
    op(0, 1, 8'h05, 16'h5555, "R4");
    chk(cnt[0] == n + 1 && last_cmd[0] == 2, "R4 owned invalidate", last_cmd[0], 2);
    op(0, 1, 8'h05, 16'h5556, "R3");
    chk(cnt[0] == n + 1, "R3 modified silent", cnt[0], n + 1);

    // R10: request held while the bus is withheld
    hold = 1'b1;
    @(negedge clk);
    cpu_valid[0] = 1'b1; cpu_write[0] = 1'b0; cpu_addr[0] = 8'h06;
    @(negedge clk);
    cpu_valid[0] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!cpu_ready[0], "R10 busy ready low", int'(cpu_ready[0]), 0);
      chk(bus_req[0] && bus_addr[0] == 8'h06 && bus_cmd[0] == 2'd0,
          "R10 request held", int'(bus_addr[0]), 6);
    end
    hold = 1'b0;
    while (!rsp_valid[0]) @(negedge clk);
    chk(rsp_rdata[0] == refm[6], "R10 data", int'(rsp_rdata[0]), int'(refm[6]));
    @(negedge clk);
    chk(!rsp_valid[0], "R10 one-cycle response", int'(rsp_valid[0]), 0);

    // R11: sweep of mixed traffic over conflicting addresses
    for (int k = 0; k < 240; k++) begin
      op(k % NC, ((k * 7) % 3) == 0, aset[(k * 5 / 3) % 4], 16'(k * 37 + 5), "R11 coherent read");
    end
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < 4; a++) op(c, 0, aset[a], 0, "R11 final read");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc == 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule